// File: doc/BRIEF.md
# XOR-Key Dynamic Address Remapper

This block sits between a memory controller and a small nonvolatile array and spreads wear across the array. Each incoming logical line address is turned into a physical address by XOR with one of two keys. The older key describes where data still sits. The newer key describes where data is being moved to.

A counter of upstream writes triggers one refresh step every few writes. Each step looks at the line named by a refresh pointer. Unless that line was already moved as the partner of an earlier line, the step swaps it with its partner through two internal buffers. The swap is four array accesses long, and upstream traffic is held off while it runs.

When the pointer has passed every line of the region, the newer key becomes the older one and a new key is taken from a random-key input. The next round of migration then starts at line zero. A hot logical address therefore keeps drifting to new physical lines.

Top module: `xor_remap`

## Requirements
- R1: Every accepted upstream request (`up_valid` and `up_ready` both high) issues, in the same cycle, exactly one array access with the same write flag and write data, at the logical address XORed with the key chosen by R3.
- R2: After reset both keys, the refresh pointer and the write counter are zero, and `up_ready` is high, so address a maps to physical line a.
- R3: A logical address a is migrated when a is below the refresh pointer, or when a XOR old key XOR new key is below it. A migrated address uses the new key; every other address uses the old key.
- R4: Only accepted upstream writes advance the write counter. Every INTERVAL-th write (default 4) triggers one refresh step at the clock edge that accepts it. Reads never trigger a step.
- R5: A triggered step whose pointed line is not migrated runs for the next four cycles with `up_ready` low. The four cycles, in order, are: read pointer^old key, read pointer^new key, write the first read's data to pointer^new key, write the second read's data to pointer^old key. The pointer advances at the end of the fourth cycle, and `up_ready` returns high in the cycle after it.
- R6: A triggered step whose pointed line is already migrated under R3 issues no array access and never lowers `up_ready`. The pointer advances at the edge of the triggering write.
- R7: When the pointer advances from its all-ones value it wraps to zero, the new key is copied into the old key, and the new key is loaded from `key_in`. At every other time `key_in` has no effect on the mapping.
- R8: A read of a logical address returns, on `up_rdata`, the data of the most recent write to that address, across any number of swaps and key rotations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Block can accept a request (low during a swap) |
| up_addr | input | AW | Logical line address |
| up_we | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DW | Write data |
| up_rdata | output | DW | Read data returned for an accepted read |
| up_rvalid | output | 1 | `up_rdata` is valid this cycle |
| key_in | input | AW | Fresh random key, sampled at round end |
| mem_req | output | 1 | Array access this cycle |
| mem_we | output | 1 | Array access is a write |
| mem_addr | output | AW | Physical line address |
| mem_wdata | output | DW | Data written to the array |
| mem_rdata | input | DW | Array read data, combinational from `mem_addr` |

## Verification
The translation of an upstream write and the refresh bookkeeping it triggers happen in the same cycle. That write is translated with the keys and pointer as they stand before the edge. At that same edge the pointer may advance past an already-moved line and, at the last line, rotate the keys. The bench provokes this by hammering a single address across whole rounds, which drives the pointer through skipped lines and wraps while each fourth write lands. A cycle-level model with its own copy of the keys, pointer and counter predicts each physical address, each stall cycle and the moment the key from `key_in` is taken. Every read is also compared against a logical shadow memory.

// File: rtl/xor_remap.sv
`timescale 1ns/1ps
module xor_remap #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int INTERVAL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_addr,
  input  logic          up_we,
  input  logic [DW-1:0] up_wdata,
  output logic [DW-1:0] up_rdata,
  output logic          up_rvalid,
  input  logic [AW-1:0] key_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] GWC_TOP = CW'(INTERVAL - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_WR1, S_WR0} st_t;

  st_t           st;
  logic [AW-1:0] key0, key1, crp;
  logic [CW-1:0] gwc;
  logic [DW-1:0] buf0, buf1;

  wire [AW-1:0] kdiff    = key0 ^ key1;
  wire          req_new  = (up_addr < crp) || ((up_addr ^ kdiff) < crp);
  wire [AW-1:0] up_phys  = up_addr ^ (req_new ? key1 : key0);
  wire          crp_done = (crp ^ kdiff) < crp;
  wire          fire     = up_valid && up_ready;
  wire          tick     = fire && up_we && (gwc == GWC_TOP);
  wire          advance  = (tick && crp_done) || (st == S_WR0);

  assign up_ready  = (st == S_IDLE);
  assign up_rdata  = mem_rdata;
  assign up_rvalid = fire && !up_we;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = crp ^ key0;
    mem_wdata = buf1;
    unique case (st)
      S_IDLE: begin
        mem_req   = fire;
        mem_we    = fire && up_we;
        mem_addr  = up_phys;
        mem_wdata = up_wdata;
      end
      S_RD0: mem_addr = crp ^ key0;
      S_RD1: mem_addr = crp ^ key1;
      S_WR1: begin
        mem_we    = 1'b1;
        mem_addr  = crp ^ key1;
        mem_wdata = buf0;
      end
      S_WR0: begin
        mem_we    = 1'b1;
        mem_addr  = crp ^ key0;
        mem_wdata = buf1;
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      key0 <= '0;
      key1 <= '0;
      crp  <= '0;
      gwc  <= '0;
      buf0 <= '0;
      buf1 <= '0;
    end else begin
      if (fire && up_we) gwc <= tick ? '0 : gwc + 1'b1;
      unique case (st)
        S_IDLE:  if (tick && !crp_done) st <= S_RD0;
        S_RD0: begin buf0 <= mem_rdata; st <= S_RD1; end
        S_RD1: begin buf1 <= mem_rdata; st <= S_WR1; end
        S_WR1:   st <= S_WR0;
        S_WR0:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (advance) begin
        crp <= crp + 1'b1;
        if (crp == '1) begin
          key0 <= key1;
          key1 <= key_in;
        end
      end
    end
  end
endmodule

// File: rtl/xor_remap_chk.sv
`timescale 1ns/1ps
module xor_remap_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] crp,
  input logic [AW-1:0] key0,
  input logic [AW-1:0] key1
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (up_valid && up_ready) |-> mem_req); // R1
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !up_ready |-> mem_req); // R5
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(up_ready) |-> !mem_we); // R5
  AST_SECOND_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(up_ready) |=> (!up_ready && !mem_we)); // R5
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (crp != '0) |-> ($stable(key0) && $stable(key1))); // R7
endmodule

bind xor_remap xor_remap_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .mem_req(mem_req), .mem_we(mem_we), .crp(crp), .key0(key0), .key1(key1)
);

// File: tb/xor_remap_tb.sv
`timescale 1ns/1ps
module xor_remap_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int INTERVAL = 4;
  localparam int N = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_valid = 1'b0;
  logic          up_ready;
  logic [AW-1:0] up_addr = '0;
  logic          up_we = 1'b0;
  logic [DW-1:0] up_wdata = '0;
  logic [DW-1:0] up_rdata;
  logic          up_rvalid;
  logic [AW-1:0] key_in = 4'd9;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] arr [N];
  logic [DW-1:0] ref_mem [N];

  logic [AW-1:0] m_k0 = '0, m_k1 = '0, m_crp = '0;
  int            m_gwc = 0;
  int            n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  xor_remap #(.AW(AW), .DW(DW), .INTERVAL(INTERVAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_we(up_we), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .up_rvalid(up_rvalid), .key_in(key_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = arr[mem_addr];
  always @(posedge clk) if (mem_req && mem_we) arr[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] d);
    logic [AW-1:0] kd, pa, kin;
    logic nw, trig, skip;
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_we = we; up_wdata = d;
    key_in = AW'($urandom_range(1, N - 1));
    kin = key_in;
    #5;
    kd = m_k0 ^ m_k1;
    nw = (a < m_crp) || ((a ^ kd) < m_crp);
    pa = a ^ (nw ? m_k1 : m_k0);
    chk(up_ready == 1'b1, "R5 ready before request", int'(up_ready), 1);
    chk(mem_req == 1'b1 && mem_we == we, "R1 access kind", int'({mem_req, mem_we}), int'({1'b1, we}));
    chk(mem_addr == pa, "R3 R7 translated address", int'(mem_addr), int'(pa));
    if (we) chk(mem_wdata == d, "R1 write data", int'(mem_wdata), int'(d));
    else chk(up_rdata == ref_mem[a] && up_rvalid, "R8 read data", int'(up_rdata), int'(ref_mem[a]));
    @(posedge clk); #1;
    up_valid = 1'b0;
    trig = 1'b0;
    if (we) begin
      ref_mem[a] = d;
      trig = (m_gwc == INTERVAL - 1);
      m_gwc = trig ? 0 : m_gwc + 1;
    end
    skip = ((m_crp ^ kd) < m_crp);
    if (trig && !skip) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #5;
        pa = m_crp ^ ((i == 1 || i == 2) ? m_k1 : m_k0);
        chk(!up_ready && mem_req, "R5 stall", int'({up_ready, mem_req}), 1);
        chk(mem_we == (i >= 2), "R5 step kind", int'(mem_we), int'(i >= 2));
        chk(mem_addr == pa, "R5 step address", int'(mem_addr), int'(pa));
      end
    end
    if (trig) begin
      if (m_crp == AW'(N - 1)) begin
        m_k0 = m_k1;
        m_k1 = kin;
      end
      m_crp = m_crp + 1'b1;
    end
    @(negedge clk); #5;
    chk(up_ready == 1'b1, trig ? (skip ? "R6 no stall on skip" : "R5 ready after swap")
                                : "R4 no step", int'(up_ready), 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin arr[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #5;
    chk(up_ready == 1'b1 && mem_req == 1'b0, "R2 reset idle", int'({up_ready, mem_req}), 2);
    // R2: identity mapping after reset
    req(4'd5, 1'b0, '0);
    // R4: a long run of reads never stalls
    for (int i = 0; i < 12; i++) req(AW'(i), 1'b0, '0);
    // fill
    for (int i = 0; i < N; i++) req(AW'(i), 1'b1, DW'(8'h30 + i));
    // hammer one address across rounds (R6, R7 coincide with translation)
    for (int i = 0; i < 5 * N * INTERVAL; i++) req(4'd3, 1'b1, DW'($urandom));
    for (int i = 0; i < N; i++) req(AW'(i), 1'b0, '0);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic w;
      w = ($urandom_range(0, 2) != 0);
      req(AW'($urandom), w, DW'($urandom));
    end
    for (int i = 0; i < N; i++) req(AW'(i), 1'b0, '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule